// File: doc/BRIEF.md
# Soft-Ramp Zero-Cross Gain Controller

This block decides when, and in what increments, a new gain setting reaches each of two audio input channels. Each channel receives a 6-bit signed gain request in half-decibel units. The block keeps a target and an applied level for each channel, both in eighth-decibel units. It moves the applied level toward the target only on a frame strobe, which is one pulse per stereo sample frame.

Two mode inputs select how the level moves. With both modes off, the level jumps straight to the target. With ramp mode on, the level moves one eighth-decibel step per frame. With zero-cross mode on, the block waits for the channel's signal to cross zero before it changes the level. With both modes on, every single step waits for a crossing. If no crossing arrives, a shared free-running sample counter forces the change within 512 to 1024 frames. The block multiplies no samples; it supplies the level to a separate gain stage.

Top module: `gain_slew_ctrl`

## Requirements
- R1: After reset both applied levels are 0 and both busy outputs are low.
- R2: A request code is a 6-bit two's-complement number in 0.5 dB units. It becomes a target equal to the code times 4, in 1/8 dB units. So 011000 gives +96, 101000 gives -96, 000000 gives 0 and 000001 gives +4.
- R3: A request whose signed value is above +24 or below -24 (for example 011001 or 100111) is ignored, and the previous target is kept.
- R4: With ramp and zero-cross modes both off, the applied level takes the full target value at the first frame strobe after the request has been present for one clock.
- R5: With ramp on and zero-cross off, each frame strobe moves the applied level one unit (1/8 dB) toward the target.
- R6: With zero-cross on and ramp off, the whole change is applied at the first frame strobe that sees a zero crossing. A zero crossing means the sample's sign bit differs from that of the same channel's sample at the previous strobe, or the sample equals zero.
- R7: A free-running 9-bit counter advances on every frame strobe from reset, and it wraps at the strobe where its value is 511. With zero-cross on and no crossing, a pending change is forced at the second wrap counted after the change became pending.
- R8: With both modes on, each single 1/8 dB step waits for a zero crossing or for the R7 timeout. The timeout count starts again after every step.
- R9: Zero-crossing detection and the timeout are handled separately for each channel, so one channel can update while the other keeps waiting.
- R10: A new target that arrives during a ramp is approached from the current applied level, without restarting.
- R11: A channel's busy output is high exactly while its applied level differs from its target. While busy is low, a frame strobe leaves the level unchanged.
- R12: The applied levels change only on clocks where the frame strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-clock pulse per sample frame |
| ramp_en | input | 1 | Step mode: move in 1/8 dB steps |
| zc_en | input | 1 | Wait for a zero crossing before a change |
| gain_req_a | input | 6 | Channel A gain request, 0.5 dB two's complement |
| gain_req_b | input | 6 | Channel B gain request, 0.5 dB two's complement |
| samp_a | input | SAMP_W | Channel A signed sample, valid with frame_stb |
| samp_b | input | SAMP_W | Channel B signed sample, valid with frame_stb |
| applied_a | output | LVL_W | Channel A applied level, signed 1/8 dB |
| applied_b | output | LVL_W | Channel B applied level, signed 1/8 dB |
| busy_a | output | 1 | Channel A level differs from its target |
| busy_b | output | 1 | Channel B level differs from its target |

## Verification
The timeout is the hardest behaviour to reach from the ports. It depends on where the hidden free-running counter stands when a change becomes pending, and it needs hundreds of frames with no crossing. The bench counts every strobe it issues from reset, so it knows the counter phase. It holds the sample signs constant and works out the exact strobe of the second wrap, and it checks that the level holds at every strobe before that one. The same method is used again in combined mode, where the count must start over after a step that a crossing triggered.

// File: rtl/gain_slew_ctrl.sv
module gain_slew_ctrl #(
  parameter int SAMP_W   = 16,
  parameter int TMO_W    = 9,
  parameter int GAIN_MAX = 24,
  parameter int LVL_W    = $clog2(GAIN_MAX * 4 + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_stb,
  input  logic                     ramp_en,
  input  logic                     zc_en,
  input  logic [5:0]               gain_req_a,
  input  logic [5:0]               gain_req_b,
  input  logic signed [SAMP_W-1:0] samp_a,
  input  logic signed [SAMP_W-1:0] samp_b,
  output logic signed [LVL_W-1:0]  applied_a,
  output logic signed [LVL_W-1:0]  applied_b,
  output logic                     busy_a,
  output logic                     busy_b
);

  localparam int NCH = 2;

  logic [TMO_W-1:0] tmo_cnt;
  logic             wrap;

  logic [5:0]               req  [NCH];
  logic signed [SAMP_W-1:0] smp  [NCH];
  logic signed [LVL_W-1:0]  lvl  [NCH];
  logic                     busy [NCH];

  assign req[0] = gain_req_a;
  assign req[1] = gain_req_b;
  assign smp[0] = samp_a;
  assign smp[1] = samp_b;

  assign wrap = frame_stb && (&tmo_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)         tmo_cnt <= '0;
    else if (frame_stb) tmo_cnt <= tmo_cnt + 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [5:0]       code;
    logic signed [LVL_W-1:0] code_lvl, tgt, step;
    logic                    code_ok, prev_neg, wrap_seen;
    logic                    zc, pend, tmo, go;

    assign code     = $signed(req[ch]);
    assign code_ok  = (int'(code) >= -GAIN_MAX) && (int'(code) <= GAIN_MAX);
    assign code_lvl = LVL_W'(code) <<< 2;

    assign zc   = (smp[ch] == '0) || (smp[ch][SAMP_W-1] != prev_neg);
    assign pend = (lvl[ch] != tgt);
    assign tmo  = pend && wrap && wrap_seen;
    assign go   = frame_stb && pend && (!zc_en || zc || tmo);

    always_comb begin
      if (!ramp_en)           step = tgt;
      else if (tgt > lvl[ch]) step = lvl[ch] + 1'b1;
      else                    step = lvl[ch] - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt       <= '0;
        lvl[ch]   <= '0;
        prev_neg  <= 1'b0;
        wrap_seen <= 1'b0;
      end else begin
        if (code_ok)   tgt      <= code_lvl;
        if (frame_stb) prev_neg <= smp[ch][SAMP_W-1];
        if (go)        lvl[ch]  <= step;
        if (!pend || go) wrap_seen <= 1'b0;
        else if (wrap)   wrap_seen <= 1'b1;
      end
    end

    assign busy[ch] = pend;
  end

  assign applied_a = lvl[0];
  assign applied_b = lvl[1];
  assign busy_a    = busy[0];
  assign busy_b    = busy[1];

endmodule

// File: rtl/gain_slew_ctrl_chk.sv
module gain_slew_ctrl_chk #(
  parameter int LVL_W   = 8,
  parameter int LVL_MAX = 96
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    frame_stb,
  input logic                    ramp_en,
  input logic signed [LVL_W-1:0] applied_a,
  input logic signed [LVL_W-1:0] applied_b,
  input logic                    busy_a,
  input logic                    busy_b
);

  // R12
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(applied_a));

  // R12
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(applied_b));

  // R5
  ramp_step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && ramp_en) |=>
      (int'(applied_a) - int'($past(applied_a)) <= 1) &&
      (int'(applied_a) - int'($past(applied_a)) >= -1));

  // R5
  ramp_step_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && ramp_en) |=>
      (int'(applied_b) - int'($past(applied_b)) <= 1) &&
      (int'(applied_b) - int'($past(applied_b)) >= -1));

  // R2
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(applied_a) <= LVL_MAX) && (int'(applied_a) >= -LVL_MAX) &&
    (int'(applied_b) <= LVL_MAX) && (int'(applied_b) >= -LVL_MAX));

  // R11
  idle_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !busy_a) |=> $stable(applied_a));

  // R11
  idle_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !busy_b) |=> $stable(applied_b));

endmodule

bind gain_slew_ctrl gain_slew_ctrl_chk #(.LVL_W(LVL_W), .LVL_MAX(GAIN_MAX * 4)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ramp_en(ramp_en),
  .applied_a(applied_a), .applied_b(applied_b), .busy_a(busy_a), .busy_b(busy_b)
);

// File: tb/gain_slew_ctrl_tb_top.sv
module gain_slew_ctrl_tb_top;
  localparam int SW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_stb = 1'b0, ramp_en = 1'b0, zc_en = 1'b0;
  logic [5:0] gain_req_a = '0, gain_req_b = '0;
  logic signed [SW-1:0] samp_a = 16'sd100, samp_b = 16'sd100;
  logic signed [LW-1:0] applied_a, applied_b;
  logic busy_a, busy_b;

  int checks = 0, fails = 0, nframes = 0;

  always #4 clk = ~clk;

  gain_slew_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ramp_en(ramp_en), .zc_en(zc_en),
    .gain_req_a(gain_req_a), .gain_req_b(gain_req_b), .samp_a(samp_a), .samp_b(samp_b),
    .applied_a(applied_a), .applied_b(applied_b), .busy_a(busy_a), .busy_b(busy_b)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic strobe(input int sa, input int sb);
    @(negedge clk);
    samp_a = SW'(sa); samp_b = SW'(sb); frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    nframes++;
  endtask

  task automatic set_req(input logic [5:0] a, input logic [5:0] b);
    @(negedge clk);
    gain_req_a = a; gain_req_b = b;
    @(negedge clk);
  endtask

  function automatic int second_wrap(input int p);
    int n = p;
    while (n % 512 != 511) n++;
    return n + 512;
  endfunction

  task automatic t_reset;
    chk(applied_a == 0 && applied_b == 0, "R1 level", int'(applied_a), 0);
    chk(!busy_a && !busy_b, "R1 busy", int'(busy_a), 0);
  endtask

  task automatic t_jump;
    ramp_en = 0; zc_en = 0;
    set_req(6'b011000, 6'b101000);
    chk(applied_a == 0, "R12 held before strobe", int'(applied_a), 0);
    chk(busy_a && busy_b, "R11 busy pending", int'(busy_a), 1);
    strobe(100, 100);
    chk(applied_a == 96, "R4 R2 jump +12dB", int'(applied_a), 96);
    chk(applied_b == -96, "R2 jump -12dB", int'(applied_b), -96);
    chk(!busy_a && !busy_b, "R11 busy clear", int'(busy_a), 0);
    set_req(6'b000001, 6'b000000);
    strobe(100, 100);
    chk(applied_a == 4 && applied_b == 0, "R2 half dB", int'(applied_a), 4);
  endtask

  task automatic t_reserved;
    set_req(6'b011001, 6'b100111);
    chk(!busy_a && !busy_b, "R3 busy after reserved", int'(busy_b), 0);
    strobe(100, 100);
    chk(applied_a == 4, "R3 reserved A ignored", int'(applied_a), 4);
    chk(applied_b == 0, "R3 reserved B ignored", int'(applied_b), 0);
  endtask

  task automatic t_ramp;
    set_req(6'b000000, 6'b000000);
    strobe(100, 100);
    ramp_en = 1;
    set_req(6'b000010, 6'b000000);
    for (int i = 0; i < 3; i++) strobe(100, 100);
    chk(applied_a == 3, "R5 three steps", int'(applied_a), 3);
    chk(busy_a, "R11 busy mid ramp", int'(busy_a), 1);
    set_req(6'b111111, 6'b000000);
    strobe(100, 100);
    chk(applied_a == 2, "R10 retarget continues", int'(applied_a), 2);
    for (int i = 0; i < 6; i++) strobe(100, 100);
    chk(applied_a == -4 && !busy_a, "R5 R10 reached", int'(applied_a), -4);
    strobe(100, 100);
    chk(applied_a == -4, "R11 idle hold", int'(applied_a), -4);
    ramp_en = 0;
  endtask

  task automatic t_zc;
    zc_en = 1;
    strobe(100, 100);
    set_req(6'b000100, 6'b111100);
    strobe(100, 100);
    chk(applied_a == -4 && applied_b == 0, "R6 no crossing", int'(applied_a), -4);
    strobe(-5, 7);
    chk(applied_a == 16, "R6 sign change", int'(applied_a), 16);
    chk(applied_b == 0 && busy_b, "R9 B still waits", int'(applied_b), 0);
    strobe(-6, 0);
    chk(applied_b == -16, "R6 zero sample", int'(applied_b), -16);
  endtask

  task automatic t_timeout;
    int exp_n, bad = 0;
    strobe(100, 100);
    set_req(6'b000000, 6'b000000);
    exp_n = second_wrap(nframes);
    while (nframes < exp_n) begin
      strobe(100, 100);
      if (applied_a != 16 || applied_b != -16) bad++;
    end
    chk(bad == 0, "R7 held until timeout", bad, 0);
    strobe(100, 100);
    chk(applied_a == 0 && applied_b == 0, "R7 forced at second wrap", int'(applied_a), 0);
  endtask

  task automatic t_both;
    int exp_n, bad = 0;
    ramp_en = 1; zc_en = 1;
    set_req(6'b000001, 6'b000000);
    strobe(100, 100);
    chk(applied_a == 0, "R8 step waits", int'(applied_a), 0);
    strobe(-100, 100);
    chk(applied_a == 1, "R8 step on crossing", int'(applied_a), 1);
    strobe(100, 100);
    chk(applied_a == 2, "R8 second crossing", int'(applied_a), 2);
    exp_n = second_wrap(nframes);
    while (nframes < exp_n) begin
      strobe(100, 100);
      if (applied_a != 2) bad++;
    end
    chk(bad == 0, "R8 held before timeout", bad, 0);
    strobe(100, 100);
    chk(applied_a == 3, "R8 step on timeout", int'(applied_a), 3);
    chk(applied_b == 0, "R9 B untouched", int'(applied_b), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_jump();
    t_reserved();
    t_ramp();
    t_zc();
    t_timeout();
    t_both();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule